// File: doc/BRIEF.md
# Time-Gain Control Step Sequencer

This block drives the gain of a receive chain during one acquisition line. Gain rises with echo depth in a staircase: the line is split into a fixed number of equal time segments, 32 by default, and each segment applies its own 10-bit code from a small writable table. A pulse on `line_start` begins a line. The block then counts enabled sample ticks and moves to the next table entry each time a segment's tick budget is spent. The default budget is 512 ticks, which gives 8 µs per step at 64 MHz and 256 µs for the whole line.

After the last segment the block returns to idle. In idle it presents a fixed idle code until the next line start. The output `dac_code` is the level that a serializer for the DAC picks up; it can also be read back at any time, in a line or outside one.

Table entries are loaded through a valid/ready write port. `wr_ready` is tied high, so the port never applies back-pressure. Every cycle in which `wr_valid` is high writes `wr_data` into entry `wr_addr`. A write changes the table straight away, but `dac_code` is loaded only at line start and at segment boundaries. A write therefore reaches the output no earlier than the next boundary.

Top module: `tgc_sequencer`

## Requirements
- R1: While reset is held and after it, `line_active` is 0, `seg_idx` is 0 and `dac_code` equals `IDLE_CODE` (0 by default).
- R2: The table holds `ENTRIES` (32) codes of `CODE_W` (10) bits each, covering the full range 0 to 1023. `wr_ready` is always 1, and each cycle with `wr_valid` high stores `wr_data` at entry `wr_addr`.
- R3: In the cycle after `line_start` is sampled high, `line_active` is 1, `seg_idx` is 0 and `dac_code` is table entry 0.
- R4: A segment lasts `SEG_TICKS` (512) cycles in which `tick_en` is high. Cycles with `tick_en` low do not count. In the cycle after the last tick of a segment, `seg_idx` goes up by one and `dac_code` shows the next entry.
- R5: When the final segment (index `ENTRIES-1`) ends, `line_active` falls, `seg_idx` returns to 0 and `dac_code` goes back to `IDLE_CODE`. These outputs hold until the next `line_start`, and `tick_en` has no effect while the block is idle.
- R6: A table write never changes the current `dac_code`. A load at a boundary reads the table as it stood before that clock edge, so a write in the same cycle as the load is not seen until that entry is next loaded.
- R7: A `line_start` during a line restarts the line at segment 0 and clears the tick count.
- R8: `dac_code` changes only in the cycle after a line start or a segment end.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_start | input | 1 | One-cycle pulse that begins a line |
| tick_en | input | 1 | Sample tick enable; each high cycle counts toward the segment |
| wr_valid | input | 1 | Table write request |
| wr_ready | output | 1 | Write acceptance, always 1 |
| wr_addr | input | $clog2(ENTRIES) | Table entry to write |
| wr_data | input | CODE_W | Gain code to store |
| dac_code | output | CODE_W | Current gain code for the DAC |
| seg_idx | output | $clog2(ENTRIES) | Index of the active segment |
| line_active | output | 1 | High while a line is in progress |

## Verification
On every cycle the assertions check the following:
- the idle outputs (R1, R5);
- the state one cycle after a line start (R3);
- that the index only ever steps by one, and that a line only ends from the last segment (R4, R5);
- that the tick counter stays below the segment length (R4);
- that `dac_code` holds between load events (R8);
- that `wr_ready` stays high (R2).

The correct code values, the exact boundary cycles under sparse tick patterns, the rule that a same-cycle write is not seen (R6), and restart in mid-line (R7) all depend on table contents and on timing. Only the bench scenarios show these. They compare the outputs against a reference that is recomputed every cycle, using a short segment length so that complete lines can be swept.

// File: rtl/tgc_pkg.sv
package tgc_pkg;

  typedef enum logic {
    TGC_IDLE = 1'b0,
    TGC_RUN  = 1'b1
  } tgc_phase_e;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/tgc_gain_table.sv
module tgc_gain_table #(
  parameter int ENTRIES = 32,
  parameter int CODE_W  = 10,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [CODE_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_addr,
  output logic [CODE_W-1:0] rd_data
);

  logic [CODE_W-1:0] entry_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic [CODE_W-1:0] q;
    logic              hit;

    assign hit = wr_en && (wr_addr == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q <= '0;
      end else if (hit) begin
        q <= wr_data;
      end
    end

    assign entry_q[e] = q;
  end

  assign rd_data = entry_q[rd_addr];

endmodule

// File: rtl/tgc_seg_timer.sv
module tgc_seg_timer #(
  parameter int SEG_TICKS = 512,
  parameter int CNT_W     = tgc_pkg::cnt_width(SEG_TICKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic             tick_en,
  output logic             seg_done,
  output logic [CNT_W-1:0] tick_cnt
);

  localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(SEG_TICKS - 1);

  logic at_last;

  assign at_last  = (tick_cnt == LAST_TICK);
  assign seg_done = run && tick_en && at_last && !clear;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_cnt <= '0;
    end else if (clear) begin
      tick_cnt <= '0;
    end else if (run && tick_en) begin
      tick_cnt <= at_last ? '0 : tick_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/tgc_step_ctrl.sv
module tgc_step_ctrl #(
  parameter int              ENTRIES   = 32,
  parameter int              CODE_W    = 10,
  parameter int              IDX_W     = $clog2(ENTRIES),
  parameter logic [CODE_W-1:0] IDLE_CODE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic              seg_done,
  input  logic [CODE_W-1:0] rd_data,
  output logic [IDX_W-1:0]  rd_addr,
  output logic [CODE_W-1:0] dac_code,
  output logic [IDX_W-1:0]  seg_idx,
  output logic              line_active
);

  import tgc_pkg::*;

  localparam logic [IDX_W-1:0] LAST_SEG = IDX_W'(ENTRIES - 1);

  tgc_phase_e phase_q;
  logic       last_seg;

  assign last_seg    = (seg_idx == LAST_SEG);
  assign rd_addr     = line_start ? '0 : seg_idx + 1'b1;
  assign line_active = (phase_q == TGC_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q  <= TGC_IDLE;
      seg_idx  <= '0;
      dac_code <= IDLE_CODE;
    end else if (line_start) begin
      phase_q  <= TGC_RUN;
      seg_idx  <= '0;
      dac_code <= rd_data;
    end else if (seg_done) begin
      if (last_seg) begin
        phase_q  <= TGC_IDLE;
        seg_idx  <= '0;
        dac_code <= IDLE_CODE;
      end else begin
        seg_idx  <= seg_idx + 1'b1;
        dac_code <= rd_data;
      end
    end
  end

endmodule

// File: rtl/tgc_sequencer.sv
module tgc_sequencer #(
  parameter int                ENTRIES   = 32,
  parameter int                CODE_W    = 10,
  parameter int                SEG_TICKS = 512,
  parameter logic [CODE_W-1:0] IDLE_CODE = '0,
  localparam int               IDX_W     = $clog2(ENTRIES),
  localparam int               CNT_W     = tgc_pkg::cnt_width(SEG_TICKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic              tick_en,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [CODE_W-1:0] wr_data,
  output logic [CODE_W-1:0] dac_code,
  output logic [IDX_W-1:0]  seg_idx,
  output logic              line_active
);

  logic              wr_en;
  logic              seg_done;
  logic [CNT_W-1:0]  tick_cnt;
  logic [IDX_W-1:0]  rd_addr;
  logic [CODE_W-1:0] rd_data;

  assign wr_ready = 1'b1;
  assign wr_en    = wr_valid && wr_ready;

  tgc_gain_table #(
    .ENTRIES (ENTRIES),
    .CODE_W  (CODE_W),
    .IDX_W   (IDX_W)
  ) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  tgc_seg_timer #(
    .SEG_TICKS (SEG_TICKS),
    .CNT_W     (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (line_start),
    .run      (line_active),
    .tick_en  (tick_en),
    .seg_done (seg_done),
    .tick_cnt (tick_cnt)
  );

  tgc_step_ctrl #(
    .ENTRIES   (ENTRIES),
    .CODE_W    (CODE_W),
    .IDX_W     (IDX_W),
    .IDLE_CODE (IDLE_CODE)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_start  (line_start),
    .seg_done    (seg_done),
    .rd_data     (rd_data),
    .rd_addr     (rd_addr),
    .dac_code    (dac_code),
    .seg_idx     (seg_idx),
    .line_active (line_active)
  );

endmodule

// File: rtl/tgc_sequencer_chk.sv
module tgc_sequencer_chk #(
  parameter int                ENTRIES   = 32,
  parameter int                CODE_W    = 10,
  parameter int                SEG_TICKS = 512,
  parameter logic [CODE_W-1:0] IDLE_CODE = '0,
  parameter int                IDX_W     = $clog2(ENTRIES),
  parameter int                CNT_W     = tgc_pkg::cnt_width(SEG_TICKS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              line_start,
  input logic              wr_ready,
  input logic              seg_done,
  input logic [CNT_W-1:0]  tick_cnt,
  input logic [CODE_W-1:0] dac_code,
  input logic [IDX_W-1:0]  seg_idx,
  input logic              line_active
);

  localparam logic [IDX_W-1:0] LAST_SEG = IDX_W'(ENTRIES - 1);

  assert_idle_outputs_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !line_active |-> (dac_code == IDLE_CODE) && (seg_idx == '0));

  assert_always_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready);

  assert_start_enters_seg0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> line_active && (seg_idx == '0));

  assert_index_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (line_active && $past(line_active) && !$past(line_start)) |->
      ((seg_idx == $past(seg_idx)) || (seg_idx == IDX_W'($past(seg_idx) + 1'b1))));

  assert_tick_count_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick_cnt <= CNT_W'(SEG_TICKS - 1));

  assert_end_only_from_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_active) |-> ($past(seg_idx) == LAST_SEG) && !$past(line_start));

  assert_code_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(line_start) && !$past(seg_done)) |-> $stable(dac_code));

endmodule

bind tgc_sequencer tgc_sequencer_chk #(
  .ENTRIES   (ENTRIES),
  .CODE_W    (CODE_W),
  .SEG_TICKS (SEG_TICKS),
  .IDLE_CODE (IDLE_CODE),
  .IDX_W     (IDX_W),
  .CNT_W     (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .line_start  (line_start),
  .wr_ready    (wr_ready),
  .seg_done    (seg_done),
  .tick_cnt    (tick_cnt),
  .dac_code    (dac_code),
  .seg_idx     (seg_idx),
  .line_active (line_active)
);

// File: tb/tgc_sequencer_tb.sv
module tgc_sequencer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES    = 32;
  localparam int CODE_W     = 10;
  localparam int SEG        = 4;
  localparam int IDLE       = 0;
  localparam int IDX_W      = $clog2(ENTRIES);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              line_start = 1'b0;
  logic              tick_en = 1'b0;
  logic              wr_valid = 1'b0;
  logic              wr_ready;
  logic [IDX_W-1:0]  wr_addr = '0;
  logic [CODE_W-1:0] wr_data = '0;
  logic [CODE_W-1:0] dac_code;
  logic [IDX_W-1:0]  seg_idx;
  logic              line_active;

  int n_checks = 0;
  int n_fails  = 0;

  // reference state, computed from the requirements
  int m_tab [ENTRIES];
  int m_act = 0;
  int m_seg = 0;
  int m_cnt = 0;
  int m_code = IDLE;

  always #(CLK_PERIOD/2) clk = ~clk;

  tgc_sequencer #(
    .ENTRIES   (ENTRIES),
    .CODE_W    (CODE_W),
    .SEG_TICKS (SEG),
    .IDLE_CODE (CODE_W'(IDLE))
  ) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_start  (line_start),
    .tick_en     (tick_en),
    .wr_valid    (wr_valid),
    .wr_ready    (wr_ready),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .dac_code    (dac_code),
    .seg_idx     (seg_idx),
    .line_active (line_active)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_seg = 0; m_cnt = 0; m_code = IDLE;
      for (int i = 0; i < ENTRIES; i++) m_tab[i] = 0;
    end else begin
      if (line_start) begin
        m_act = 1; m_seg = 0; m_cnt = 0; m_code = m_tab[0];
      end else if (m_act == 1 && tick_en) begin
        if (m_cnt == SEG - 1) begin
          m_cnt = 0;
          if (m_seg == ENTRIES - 1) begin
            m_act = 0; m_seg = 0; m_code = IDLE;
          end else begin
            m_seg = m_seg + 1; m_code = m_tab[m_seg];
          end
        end else begin
          m_cnt = m_cnt + 1;
        end
      end
      if (wr_valid) m_tab[wr_addr] = wr_data;
    end
  end

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    cmp(tag, "dac_code", int'(dac_code), m_code);
    cmp(tag, "seg_idx", int'(seg_idx), m_seg);
    cmp(tag, "line_active", int'(line_active), m_act);
    cmp("R2", "wr_ready", int'(wr_ready), 1);
  endtask

  // drive at negedge, compare at the next negedge
  task automatic cyc(input string tag, input bit ls, input bit te,
                     input bit wv, input int wa, input int wd);
    line_start = ls;
    tick_en    = te;
    wr_valid   = wv;
    wr_addr    = IDX_W'(wa);
    wr_data    = CODE_W'(wd);
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // R2: fill table with full-range values, outputs stay idle
    for (int i = 0; i < ENTRIES; i++) begin
      int v;
      v = (i * 37 + 11) % 1024;
      if (i == 5) v = 1023;
      if (i == 6) v = 0;
      cyc("R2", 1'b0, 1'b1, 1'b1, i, v);
    end

    // R3/R4: continuous ticks through a full line, R5: idle after
    cyc("R3", 1'b1, 1'b1, 1'b0, 0, 0);
    for (int k = 0; k < ENTRIES * SEG + 2; k++) cyc("R4", 1'b0, 1'b1, 1'b0, 0, 0);
    for (int k = 0; k < 10; k++) cyc("R5", 1'b0, 1'b1, 1'b0, 0, 0);

    // R4/R8: sparse ticks, every third cycle
    cyc("R3", 1'b1, 1'b0, 1'b0, 0, 0);
    for (int k = 0; k < ENTRIES * SEG * 3 + 6; k++)
      cyc("R8", 1'b0, (k % 3) == 2, 1'b0, 0, 0);

    // R6: writes during a line (current entry, same-cycle load, next entry)
    cyc("R6", 1'b1, 1'b1, 1'b0, 0, 0);
    for (int j = 0; j < ENTRIES * SEG + 2; j++) begin
      if (j == 5)      cyc("R6", 1'b0, 1'b1, 1'b1, 1, 999);
      else if (j == 7) cyc("R6", 1'b0, 1'b1, 1'b1, 2, 444);
      else if (j == 8) cyc("R6", 1'b0, 1'b1, 1'b1, 3, 777);
      else             cyc("R6", 1'b0, 1'b1, 1'b0, 0, 0);
    end

    // R6: entry 2 now holds the value written at the load cycle
    cyc("R6", 1'b1, 1'b1, 1'b0, 0, 0);
    for (int j = 0; j < 3 * SEG; j++) cyc("R6", 1'b0, 1'b1, 1'b0, 0, 0);

    // R7: restart mid-line
    for (int j = 0; j < 50; j++) cyc("R7", 1'b0, 1'b1, 1'b0, 0, 0);
    cyc("R7", 1'b1, 1'b1, 1'b0, 0, 0);
    for (int j = 0; j < ENTRIES * SEG + 3; j++) cyc("R7", 1'b0, 1'b1, 1'b0, 0, 0);

    // R4: no ticks, no advance
    cyc("R4", 1'b1, 1'b0, 1'b0, 0, 0);
    for (int j = 0; j < 20; j++) cyc("R4", 1'b0, 1'b0, 1'b0, 0, 0);
    cmp("R4", "seg_idx held", int'(seg_idx), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule